// File: doc/BRIEF.md
# Aliased Register Window Address Decoder

This block sits in a controller wrapper between the slave bus and the register files behind it. It classifies each incoming 64-bit address in one of three ways. The address may hit the core-configuration register window, hit the address-translation register window, or miss both. A miss passes through as an ordinary memory/BAR access. The decode is purely combinational, and it also returns the 12-bit offset of the access inside the window that was hit.

Three 64-bit settings, each programmable, define where the windows sit:
- an aperture size;
- a base for the configuration window;
- a base for the translation window.

Each setting is written as two 32-bit halves through a simple write port. The windows repeat at every multiple of the aperture size, because matching is done on the address reduced modulo that size. Programming the size to all ones removes the repetition, and each window then answers only at its absolute base. Any address that lands in a repeated copy is claimed by the registers. Software must therefore either keep BAR ranges clear of every copy or turn the aliasing off.

Top module: `mirror_win_decoder`

## Requirements
- R1: After reset the aperture size is 0x0000_0000_0100_0000, the configuration-window base is 0x0 and the translation-window base is 0x1000.
- R2: When `wr_en` is high, `wr_sel` picks one 32-bit half:
  - 0 is the size low half and 1 is the size high half.
  - 2 is the configuration base low half and 3 is its high half.
  - 4 is the translation base low half and 5 is its high half.
  - 6 and 7 change nothing.
  
  The new value applies from the cycle after the clock edge, and the other half of the same setting keeps its value.
- R3: With a power-of-two aperture size S, both the address and the base are reduced modulo S before matching. Each window therefore appears again at every multiple of S.
- R4: Each window is 4096 bytes long. A window hits when the reduced address minus the reduced base, taken as an unsigned 64-bit difference, is below 4096.
- R5: An all-ones aperture size turns off aliasing, and each window then hits only within 4096 bytes above its absolute 64-bit base.
- R6: When both windows match the same address, the configuration window is reported and the translation window is not.
- R7: Exactly one of `hit_cfg`, `hit_xlt` and `pass_thru` is high at any time. `pass_thru` is high when neither window matches.
- R8: `win_off` is the reduced address minus the reduced base of the reported window, in bits 11:0. It is 0 on a pass-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Settings write strobe |
| wr_sel | input | 3 | Selects which 32-bit setting half is written |
| wr_data | input | 32 | Write data |
| addr | input | 64 | Slave bus address to classify |
| hit_cfg | output | 1 | Address targets the configuration window |
| hit_xlt | output | 1 | Address targets the translation window |
| pass_thru | output | 1 | Address goes to memory/BAR space |
| win_off | output | 12 | Offset inside the reported window |

## Verification
The bench probes three kinds of address:
- Aliased copies at several aperture sizes, where a decoder that skipped the modulo would pass the copies through.
- The last byte of a window and the first byte after it, to catch an off-by-one limit.
- Addresses just below a base, where a signed or unmasked compare would wrongly hit.

It also overlaps the two windows to show that configuration wins and that the offsets differ per window. With aliasing off, it confirms that former alias addresses now pass through. Writes to one half, or to the unused select codes, are checked at the decode outputs, so a design that cleared the neighbouring half or honoured codes 6 and 7 would move a window.

// File: rtl/mwd_pkg.sv
// Package: shared constants and the select codes for the settings write port.
// Assumes the address is twice as wide as one write-data word.
package mwd_pkg;
    localparam int ADDR_W     = 64;
    localparam int WORD_W     = 32;
    localparam int WIN_LOG2   = 12;
    localparam int SEL_W      = 3;

    // Which 32-bit half a write lands in; codes 6 and 7 are unused.
    typedef enum logic [SEL_W-1:0] {
        SEL_SIZE_LO = 3'd0,
        SEL_SIZE_HI = 3'd1,
        SEL_CFG_LO  = 3'd2,
        SEL_CFG_HI  = 3'd3,
        SEL_XLT_LO  = 3'd4,
        SEL_XLT_HI  = 3'd5
    } set_sel_e;

    localparam int NUM_WORDS = 6;
endpackage

// File: rtl/mwd_cfg_regs.sv
// Module: holds the aperture size and the two window bases as 32-bit halves.
// Assumes ADDR_W == 2*WORD_W. A write lands on the next clock edge.
module mwd_cfg_regs #(
    parameter int ADDR_W = mwd_pkg::ADDR_W,
    parameter int WORD_W = mwd_pkg::WORD_W,
    parameter int SEL_W  = mwd_pkg::SEL_W,
    parameter logic [ADDR_W-1:0] SIZE_RST = 64'h0000_0000_0100_0000,
    parameter logic [ADDR_W-1:0] CFG_RST  = 64'h0,
    parameter logic [ADDR_W-1:0] XLT_RST  = 64'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] size_o,
    output logic [ADDR_W-1:0] cfg_base_o,
    output logic [ADDR_W-1:0] xlt_base_o
);
    localparam int NWORDS = mwd_pkg::NUM_WORDS;

    logic [WORD_W-1:0] word_q [NWORDS];

    // One register per 32-bit half, each with its own reset value.
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        localparam logic [ADDR_W-1:0] FULL_RST =
            (g < 2) ? SIZE_RST : (g < 4) ? CFG_RST : XLT_RST;
        localparam logic [WORD_W-1:0] HALF_RST =
            (g % 2 == 1) ? FULL_RST[ADDR_W-1:WORD_W] : FULL_RST[WORD_W-1:0];

        // Purpose: reset or load this half when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g] <= HALF_RST;
            else if (wr_en && wr_sel == SEL_W'(g))
                word_q[g] <= wr_data;
        end
    end

    assign size_o     = {word_q[1], word_q[0]};
    assign cfg_base_o = {word_q[3], word_q[2]};
    assign xlt_base_o = {word_q[5], word_q[4]};

    // A low-half size write lands next cycle and leaves the high half alone.
    p_size_lo_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == mwd_pkg::SEL_SIZE_LO |=>
            size_o[WORD_W-1:0] == $past(wr_data) &&
            size_o[ADDR_W-1:WORD_W] == $past(size_o[ADDR_W-1:WORD_W]))
        else $error("size low write");

    // The unused select codes change no setting.
    p_unused_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel > SEL_W'(NWORDS - 1) |=>
            $stable(size_o) && $stable(cfg_base_o) && $stable(xlt_base_o))
        else $error("unused select changed state");
endmodule

// File: rtl/mwd_win_match.sv
// Module: tests one address against one window after reducing both by a mask.
// Assumes the mask is all ones, or the aperture size minus one for a
// power-of-two size. A hit needs an unsigned difference below 2**WIN_LOG2.
module mwd_win_match #(
    parameter int ADDR_W   = mwd_pkg::ADDR_W,
    parameter int WIN_LOG2 = mwd_pkg::WIN_LOG2
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   mask_i,
    output logic                hit_o,
    output logic [WIN_LOG2-1:0] off_o
);
    logic [ADDR_W-1:0] diff;

    // Purpose: compute the distance above the base inside the aperture.
    always_comb begin
        diff  = (addr_i & mask_i) - (base_i & mask_i);
        hit_o = (diff[ADDR_W-1:WIN_LOG2] == '0);
        off_o = diff[WIN_LOG2-1:0];
    end
endmodule

// File: rtl/mirror_win_decoder.sv
// Module: top of the decoder. It turns the aperture size into an address
// mask, matches both windows and picks one target with configuration first.
// Assumes the size is a power of two or all ones. The decode is
// combinational from addr and the held settings.
module mirror_win_decoder #(
    parameter int ADDR_W   = mwd_pkg::ADDR_W,
    parameter int WORD_W   = mwd_pkg::WORD_W,
    parameter int SEL_W    = mwd_pkg::SEL_W,
    parameter int WIN_LOG2 = mwd_pkg::WIN_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit_cfg,
    output logic                hit_xlt,
    output logic                pass_thru,
    output logic [WIN_LOG2-1:0] win_off
);
    localparam logic [ADDR_W-1:0] WIN_LEN = ADDR_W'(1) << WIN_LOG2;

    logic [ADDR_W-1:0]   size, cfg_base, xlt_base, mask;
    logic                cfg_m, xlt_m;
    logic [WIN_LOG2-1:0] cfg_off, xlt_off;

    mwd_cfg_regs #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .size_o(size), .cfg_base_o(cfg_base),
        .xlt_base_o(xlt_base)
    );

    // Purpose: an all-ones size disables aliasing, otherwise keep the low bits.
    always_comb begin
        mask = (&size) ? '1 : size - ADDR_W'(1);
    end

    mwd_win_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_cfg (
        .addr_i(addr), .base_i(cfg_base), .mask_i(mask),
        .hit_o(cfg_m), .off_o(cfg_off)
    );

    mwd_win_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_xlt (
        .addr_i(addr), .base_i(xlt_base), .mask_i(mask),
        .hit_o(xlt_m), .off_o(xlt_off)
    );

    // Purpose: choose one target, configuration window before translation.
    always_comb begin
        hit_cfg   = cfg_m;
        hit_xlt   = xlt_m && !cfg_m;
        pass_thru = !cfg_m && !xlt_m;
        win_off   = cfg_m ? cfg_off : (xlt_m ? xlt_off : '0);
    end

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({hit_cfg, hit_xlt, pass_thru}))
        else $error("targets not one-hot");

    p_cfg_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_m && xlt_m |-> hit_cfg && !hit_xlt)
        else $error("translation won an overlap");

    p_pass_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_thru |-> win_off == '0)
        else $error("offset nonzero on pass-through");

    p_absolute_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (&size) && hit_cfg |-> (addr - cfg_base) < WIN_LEN)
        else $error("alias hit with aliasing off");
endmodule

// File: tb/mirror_win_decoder_tb.sv
module mirror_win_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [63:0] addr = '0;
    logic        hit_cfg, hit_xlt, pass_thru;
    logic [11:0] win_off;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] a;
        logic        hc, hx, pt;
        logic [11:0] off;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    mirror_win_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .addr(addr), .hit_cfg(hit_cfg),
        .hit_xlt(hit_xlt), .pass_thru(pass_thru), .win_off(win_off)
    );

    // Driver: present an address and queue what the requirements predict.
    task automatic probe(input logic [63:0] a, input logic hc, input logic hx,
                         input logic [11:0] off, input string req);
        exp_t e;
        @(posedge clk); #1;
        addr  = a;
        e.a = a; e.hc = hc; e.hx = hx; e.pt = !hc && !hx;
        e.off = off; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Monitor: compare on the falling edge, away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (hit_cfg !== e.hc || hit_xlt !== e.hx ||
                    pass_thru !== e.pt || win_off !== e.off) begin
                    errors++;
                    $display("FAIL %s addr=%h got cfg=%b xlt=%b pass=%b off=%h exp cfg=%b xlt=%b pass=%b off=%h",
                             e.req, e.a, hit_cfg, hit_xlt, pass_thru, win_off,
                             e.hc, e.hx, e.pt, e.off);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values; R3 aliasing at the 16 MB default
        probe(64'h0,            1, 0, 12'h000, "R1");
        probe(64'hFFF,          1, 0, 12'hFFF, "R1");
        probe(64'h1000,         0, 1, 12'h000, "R1");
        probe(64'h2000,         0, 0, 12'h000, "R7");
        probe(64'h0100_0000,    1, 0, 12'h000, "R3");
        probe(64'h0300_1234,    0, 1, 12'h234, "R3");
        probe(64'h00FF_FFFF,    0, 0, 12'h000, "R8");
        // R3 256 MB aperture
        wr(3'd0, 32'h1000_0000);
        probe(64'h1000_0000,    1, 0, 12'h000, "R3");
        probe(64'h1800_0000,    0, 0, 12'h000, "R3");
        probe(64'h2000_0010,    1, 0, 12'h010, "R3");
        // R3 128 MB aperture
        wr(3'd0, 32'h0800_0000);
        probe(64'h1800_0000,    1, 0, 12'h000, "R3");
        // R2 unused select code is ignored
        wr(3'd6, 32'h1234_5678);
        wr(3'd7, 32'h0000_0000);
        probe(64'h1800_0000,    1, 0, 12'h000, "R2");
        probe(64'h1000_1000,    0, 1, 12'h000, "R2");
        // R5 all-ones size
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        probe(64'h1_0000_0000,  0, 0, 12'h000, "R5");
        probe(64'h0,            1, 0, 12'h000, "R5");
        probe(64'h1000,         0, 1, 12'h000, "R5");
        probe(64'h0100_0000,    0, 0, 12'h000, "R5");
        // R2 halves of the configuration base
        wr(3'd2, 32'h1800_0000);
        probe(64'h1800_0004,    1, 0, 12'h004, "R2");
        probe(64'h0,            0, 0, 12'h000, "R2");
        wr(3'd3, 32'h0000_0001);
        probe(64'h1_1800_0004,  1, 0, 12'h004, "R2");
        probe(64'h1800_0004,    0, 0, 12'h000, "R2");
        // R6 overlap, R4 window edges, R8 offsets
        wr(3'd4, 32'h1800_0800);
        wr(3'd5, 32'h0000_0001);
        probe(64'h1_1800_0900,  1, 0, 12'h900, "R6");
        probe(64'h1_1800_07FF,  1, 0, 12'h7FF, "R8");
        probe(64'h1_1800_1000,  0, 1, 12'h800, "R4");
        probe(64'h1_1800_17FF,  0, 1, 12'hFFF, "R4");
        probe(64'h1_1800_1800,  0, 0, 12'h000, "R4");
        probe(64'h1_17FF_FFFF,  0, 0, 12'h000, "R4");
        @(posedge clk);
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule